// File: doc/BRIEF.md
# SPI ADC Channel Read Responder

This block is an SPI slave that returns sampled converter values to a bus master. Every exchange is a frame of four 16-bit words. On MOSI the master sends a command word, then the number of the channel it wants, then two filler words (normally all ones). On MISO the slave answers with two zero words, then the chosen channel's value, then a 16-bit CRC of that value. The two zero words give the slave time to decode the channel number before it has to shift the reply out.

The six channel values arrive as one flat parallel bus. The block samples SCK, SSEL and MOSI through synchronizers clocked by the system clock. The `modeSel` input picks one of two framing schemes:
- **Mode 0 (`modeSel`=0).** SCK idles low. SSEL is raised between words, and each falling edge of SSEL loads the next reply word.
- **Mode 3 (`modeSel`=1).** SCK idles high. SSEL stays low for the whole frame, or for several frames back to back, and each word is loaded on the first falling SCK edge of that word.

A frame that breaks off early, or a request for a channel that does not exist, raises `frameErr`. The flag stays set until the next frame begins.

Top module: `spi_adc_responder`

## Requirements
- R1: Words are 16 bits, shifted most significant bit first. MOSI is captured on SCK rising edges. MISO moves to its next bit on SCK falling edges.
- R2: A frame is four words. MISO carries 0x0000 in word 0 and 0x0000 in word 1.
- R3: The value of word 1 (0 to 5) selects the channel, and word 2 returns that channel's value. The value is captured when word 1 completes, so later changes on `chanData` do not affect words 2 and 3. Channel k occupies bits [16k+15:16k] of `chanData`.
- R4: Word 3 is the CRC of the word-2 value: polynomial 0x1021, initial value 0xFFFF, processed MSB first, with no final inversion.
- R5: A channel number of 6 or more returns 0x0000 in word 2 and the CRC of 0x0000 in word 3, and it sets `frameErr`.
- R6: In mode 0, `selN` goes high between words. Each falling edge of `selN` loads the next reply word, and the word position is kept while `selN` is high.
- R7: In mode 3, words follow each other with `selN` held low. Several complete frames may be sent under a single low period of `selN`.
- R8: An early rise of `selN` aborts the frame and sets `frameErr`, and the next frame starts again at word 0. An early rise is one in the middle of a word (either mode), or one before word 3 has completed (mode 3).
- R9: `frameErr` stays set until the first word of the next frame is loaded, and it is cleared at that point.
- R10: The content of the command word has no effect on the reply.
- R11: `miso` is 0 whenever `selN` is high.
- R12: After reset, `miso` and `frameErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which also samples the SPI pins |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 1 | 0 = mode 0 (SSEL pulsed between words), 1 = mode 3 (continuous); change only while `selN` is high |
| sck | input | 1 | SPI serial clock from the master |
| selN | input | 1 | Active-low slave select |
| mosi | input | 1 | Master-to-slave serial data |
| chanData | input | 96 | Six 16-bit channel values; channel k is at bits [16k+15:16k] |
| miso | output | 1 | Slave-to-master serial data; 0 while deselected |
| frameErr | output | 1 | Set by a bad channel number or an aborted frame; cleared when a new frame begins |

## Verification
Every channel number from 0 to 7 is read in both modes, against three distinct sets of channel values. This sweep separates correct channel selection from a fixed or shifted index, and it exercises both the valid-channel and bad-channel reply paths. The command word alternates between all ones and a small value, so that any dependence of the reply on the command would show. In one pass the channel inputs are inverted once word 1 has completed, which shows whether the value is captured at that point or sampled later. Separate sequences cover aborts in mid-word and between words, two frames run under one low period of `selN`, and `frameErr` remaining set while idle and clearing when the next frame begins.

// File: rtl/spi_adc_pkg.sv
package spi_adc_pkg;

  localparam int FRAME_WORDS = 4;
  localparam int IDX_W       = $clog2(FRAME_WORDS);

  // word positions inside a frame
  localparam logic [IDX_W-1:0] POS_CMD  = 2'd0;
  localparam logic [IDX_W-1:0] POS_ADDR = 2'd1;
  localparam logic [IDX_W-1:0] POS_DATA = 2'd2;
  localparam logic [IDX_W-1:0] POS_CRC  = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic             selActive;  // slave currently selected
    logic             loadTx;     // load next reply word into transmit shifter
    logic             shiftOut;   // advance transmit shifter one bit
    logic             shiftIn;    // capture one MOSI bit
    logic             inBit;      // the MOSI bit being captured
    logic             wordDone;   // this capture completes a word
    logic [IDX_W-1:0] wordIdx;    // current word position in frame
    logic             frameStart; // first word of a frame is being loaded
    logic             abort;      // frame broken off by early deselect
  } ctrl_strobe_t;

endpackage

// File: rtl/spi_adc_ctrl.sv
module spi_adc_ctrl
  import spi_adc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeSel,
  input  logic         sck,
  input  logic         selN,
  input  logic         mosi,
  output ctrl_strobe_t strb
);

  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

  // two sync stages plus one history stage per pin
  logic [2:0] sckSync;
  logic [2:0] selSync;
  logic [2:0] mosiSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckSync  <= {3{modeSel}};
      selSync  <= 3'b111;
      mosiSync <= 3'b000;
    end else begin
      sckSync  <= {sckSync[1:0], sck};
      selSync  <= {selSync[1:0], selN};
      mosiSync <= {mosiSync[1:0], mosi};
    end
  end

  logic sckRise, sckFall, selFallEdge, selRiseEdge, active;

  always_comb begin
    sckRise     = sckSync[1] & ~sckSync[2];
    sckFall     = ~sckSync[1] & sckSync[2];
    selFallEdge = selSync[2] & ~selSync[1];
    selRiseEdge = ~selSync[2] & selSync[1];
    active      = ~selSync[1];
  end

  logic [BW-1:0]    bitCnt;
  logic [IDX_W-1:0] wordIdx;
  logic             needLoad;

  logic loadTx, shiftOut, shiftIn, wordDone, abort, frameStart;

  always_comb begin
    loadTx     = active & ((~modeSel & selFallEdge) |
                           (modeSel & sckFall & needLoad));
    shiftOut   = active & sckFall & ~(modeSel & needLoad);
    shiftIn    = active & sckRise;
    wordDone   = shiftIn & (bitCnt == LAST_BIT);
    abort      = selRiseEdge & ((bitCnt != '0) | (modeSel & (wordIdx != POS_CMD)));
    frameStart = loadTx & (wordIdx == POS_CMD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      wordIdx  <= POS_CMD;
      needLoad <= 1'b0;
    end else if (selRiseEdge) begin
      bitCnt   <= '0;
      needLoad <= 1'b0;
      if (abort || modeSel) begin
        wordIdx <= POS_CMD;
      end
    end else if (selFallEdge && modeSel) begin
      bitCnt   <= '0;
      wordIdx  <= POS_CMD;
      needLoad <= 1'b1;
    end else begin
      if (loadTx) begin
        needLoad <= 1'b0;
      end
      if (shiftIn) begin
        if (wordDone) begin
          bitCnt   <= '0;
          wordIdx  <= wordIdx + 1'b1;
          needLoad <= modeSel;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.selActive  = active;
    strb.loadTx     = loadTx;
    strb.shiftOut   = shiftOut;
    strb.shiftIn    = shiftIn;
    strb.inBit      = mosiSync[1];
    strb.wordDone   = wordDone;
    strb.wordIdx    = wordIdx;
    strb.frameStart = frameStart;
    strb.abort      = abort;
  end

endmodule

// File: rtl/spi_adc_datapath.sv
module spi_adc_datapath
  import spi_adc_pkg::*;
#(
  parameter int             W        = 16,
  parameter int             NCH      = 6,
  parameter logic [W-1:0]   CRC_POLY = 16'h1021,
  parameter logic [W-1:0]   CRC_INIT = 16'hFFFF
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctrl_strobe_t   strb,
  input  logic [NCH*W-1:0] chanData,
  output logic           miso,
  output logic           frameErr
);

  function automatic logic [W-1:0] crcOf(input logic [W-1:0] d);
    logic [W-1:0] c;
    c = CRC_INIT;
    for (int i = W - 1; i >= 0; i--) begin
      if (c[W-1] ^ d[i]) c = (c << 1) ^ CRC_POLY;
      else               c = c << 1;
    end
    return c;
  endfunction

  logic [W-1:0] rxShift;
  logic [W-1:0] txShift;
  logic [W-1:0] dataLatch;

  logic [W-1:0] rxWord;
  logic         addrOk;
  logic [W-1:0] chanSel;
  logic [W-1:0] crcWord;
  logic [W-1:0] txNext;
  logic         addrDone;

  always_comb begin
    rxWord   = {rxShift[W-2:0], strb.inBit};
    addrOk   = rxWord < W'(NCH);
    addrDone = strb.wordDone & (strb.wordIdx == POS_ADDR);
  end

  // channel multiplexer
  always_comb begin
    chanSel = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rxWord == W'(i)) chanSel = chanData[i*W +: W];
    end
  end

  always_comb begin
    crcWord = crcOf(dataLatch);
    unique case (strb.wordIdx)
      POS_DATA: txNext = dataLatch;
      POS_CRC:  txNext = crcWord;
      default:  txNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift   <= '0;
      dataLatch <= '0;
    end else if (strb.shiftIn) begin
      rxShift <= rxWord;
      if (addrDone) begin
        dataLatch <= addrOk ? chanSel : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strb.loadTx) begin
      txShift <= txNext;
    end else if (strb.shiftOut) begin
      txShift <= {txShift[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameErr <= 1'b0;
    end else if (strb.abort || (addrDone && !addrOk)) begin
      frameErr <= 1'b1;
    end else if (strb.frameStart) begin
      frameErr <= 1'b0;
    end
  end

  assign miso = strb.selActive & txShift[W-1];

endmodule

// File: rtl/spi_adc_responder.sv
module spi_adc_responder
  import spi_adc_pkg::*;
#(
  parameter int           WORD_W   = 16,
  parameter int           NUM_CH   = 6,
  parameter logic [15:0]  CRC_POLY = 16'h1021,
  parameter logic [15:0]  CRC_INIT = 16'hFFFF
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     modeSel,
  input  logic                     sck,
  input  logic                     selN,
  input  logic                     mosi,
  input  logic [NUM_CH*WORD_W-1:0] chanData,
  output logic                     miso,
  output logic                     frameErr
);

  ctrl_strobe_t strb;

  spi_adc_ctrl #(
    .W(WORD_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .sck     (sck),
    .selN    (selN),
    .mosi    (mosi),
    .strb    (strb)
  );

  spi_adc_datapath #(
    .W        (WORD_W),
    .NCH      (NUM_CH),
    .CRC_POLY (WORD_W'(CRC_POLY)),
    .CRC_INIT (WORD_W'(CRC_INIT))
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .chanData (chanData),
    .miso     (miso),
    .frameErr (frameErr)
  );

endmodule

// File: rtl/spi_adc_responder_chk.sv
module spi_adc_responder_chk
  import spi_adc_pkg::*;
#(
  parameter int W   = 16,
  parameter int NCH = 6
) (
  input logic         clk,
  input logic         rstN,
  input logic         miso,
  input logic         frameErr,
  input ctrl_strobe_t strb
);

  logic [W-1:0] seenShift;
  logic [W-1:0] seenWord;

  always_ff @(posedge clk) begin
    if (!rstN)              seenShift <= '0;
    else if (strb.shiftIn)  seenShift <= {seenShift[W-2:0], strb.inBit};
  end

  assign seenWord = {seenShift[W-2:0], strb.inBit};

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strb.selActive |-> !miso);  // R11

  AST_ONE_SHIFT_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadTx, strb.shiftOut, strb.shiftIn}));  // R1

  AST_ZERO_LEAD_WORDS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadTx && (strb.wordIdx == POS_CMD || strb.wordIdx == POS_ADDR)) |=> !miso);  // R2

  AST_BAD_ADDR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wordDone && strb.wordIdx == POS_ADDR && seenWord >= W'(NCH)) |=> frameErr);  // R5

  AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> frameErr);  // R8

  AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> (strb.wordIdx == POS_CMD));  // R8

  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameStart && !strb.abort) |=> !frameErr);  // R9

endmodule

bind spi_adc_responder spi_adc_responder_chk #(
  .W   (WORD_W),
  .NCH (NUM_CH)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .miso     (miso),
  .frameErr (frameErr),
  .strb     (strb)
);

// File: tb/spi_adc_responder_tb.sv
module spi_adc_responder_tb;

  localparam int W = 16;
  localparam int N = 6;
  localparam int H = 8;  // SCK half period in clk cycles

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b0;
  logic sck = 1'b0;
  logic selN = 1'b1;
  logic mosi = 1'b0;
  logic [N*W-1:0] chanData = '0;
  logic miso;
  logic frameErr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] got [4];
  logic [W-1:0] chanVal [N];

  always #5 clk = ~clk;

  spi_adc_responder u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .sck(sck), .selN(selN),
    .mosi(mosi), .chanData(chanData), .miso(miso), .frameErr(frameErr)
  );

  // reference CRC as polynomial remainder of (d ^ init) * x^16
  function automatic logic [W-1:0] crcRef(input logic [W-1:0] d);
    logic [31:0] v;
    v = {d ^ 16'hFFFF, 16'h0000};
    for (int i = 31; i >= 16; i--) begin
      if (v[i]) v = v ^ (32'h0001_1021 << (i - 16));
    end
    return v[15:0];
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic applyChan();
    for (int i = 0; i < N; i++) chanData[i*W +: W] = chanVal[i];
  endtask

  // one word; mode 0 wraps it in its own select pulse
  task automatic doWord(input logic [W-1:0] tx, input int nbits, output logic [W-1:0] rx);
    rx = '0;
    if (!modeSel) begin
      selN = 1'b0;
      mosi = tx[W-1];
      waitClk(H);
      for (int b = 0; b < nbits; b++) begin
        rx = {rx[W-2:0], miso};
        sck = 1'b1;
        waitClk(H);
        sck = 1'b0;
        if (b + 1 < W) mosi = tx[W-2-b];
        waitClk(H);
      end
      selN = 1'b1;
      waitClk(2*H);
    end else begin
      for (int b = 0; b < nbits; b++) begin
        sck = 1'b0;
        mosi = tx[W-1-b];
        waitClk(H);
        rx = {rx[W-2:0], miso};
        sck = 1'b1;
        waitClk(H);
      end
    end
  endtask

  task automatic selLow3();
    selN = 1'b0;
    waitClk(H);
  endtask

  task automatic selHigh3();
    waitClk(H);
    selN = 1'b1;
    waitClk(2*H);
  endtask

  // four words; optionally invert channel inputs after word 1
  task automatic runWords(input logic [W-1:0] cmd, input logic [W-1:0] addr, input bit scramble);
    doWord(cmd, W, got[0]);
    doWord(addr, W, got[1]);
    if (scramble) begin
      for (int i = 0; i < N; i++) chanData[i*W +: W] = ~chanVal[i];
    end
    doWord(16'hFFFF, W, got[2]);
    doWord(16'hFFFF, W, got[3]);
    applyChan();
  endtask

  task automatic checkFrame(input int addr, input string mtag);
    logic [W-1:0] expData;
    expData = (addr < N) ? chanVal[addr] : 16'h0000;
    chk({"R2 word0 ", mtag}, got[0], 16'h0000);
    chk({"R2 word1 ", mtag}, got[1], 16'h0000);
    if (addr < N) chk({"R1/R3 data ", mtag}, got[2], expData);
    else          chk({"R5 data ", mtag}, got[2], expData);
    chk({"R4 crc ", mtag}, got[3], crcRef(expData));
    if (addr < N) chk({"R9 err clear ", mtag}, {15'd0, frameErr}, 16'd0);
    else          chk({"R5 err set ", mtag}, {15'd0, frameErr}, 16'd1);
    chk("R11 miso idle", {15'd0, miso}, 16'd0);
  endtask

  task automatic setPattern(input int p);
    for (int i = 0; i < N; i++) begin
      case (p)
        0:       chanVal[i] = 16'hA5A5 ^ 16'(i * 16'h1111);
        1:       chanVal[i] = 16'(16'h0001 << (i * 3)) | 16'h8000;
        default: chanVal[i] = 16'(16'h1234 + i * 16'h2F1D);
      endcase
    end
    applyChan();
  endtask

  task automatic setMode(input logic m);
    modeSel = m;
    sck = m;
    waitClk(4*H);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] junk;
    logic [W-1:0] cmd;
    waitClk(10);
    rstN = 1'b1;
    waitClk(4);
    chk("R12 reset miso", {15'd0, miso}, 16'd0);
    chk("R12 reset err", {15'd0, frameErr}, 16'd0);

    // sweep: both modes, three patterns, all channel numbers 0..7
    for (int m = 0; m < 2; m++) begin
      setMode(m[0]);
      for (int p = 0; p < 3; p++) begin
        setPattern(p);
        for (int a = 0; a < 8; a++) begin
          cmd = (a[0] ^ p[0]) ? 16'hFFFF : 16'h0001;  // R10 command varies
          if (m == 1) selLow3();
          runWords(cmd, 16'(a), p == 2);
          if (m == 1) selHigh3();
          checkFrame(a, m == 1 ? "R7 R10" : "R6 R10");
        end
      end
    end

    // R7: two frames under one select in mode 3
    setMode(1'b1);
    setPattern(1);
    selLow3();
    runWords(16'h0000, 16'd4, 1'b0);
    chk("R7 frameA data", got[2], chanVal[4]);
    chk("R7 frameA crc", got[3], crcRef(chanVal[4]));
    runWords(16'h0000, 16'd1, 1'b0);
    chk("R7 frameB word0", got[0], 16'h0000);
    chk("R7 frameB data", got[2], chanVal[1]);
    chk("R7 frameB crc", got[3], crcRef(chanVal[1]));
    selHigh3();

    // R8: mode 3 abort mid-word
    selLow3();
    doWord(16'h0000, W, junk);
    doWord(16'h0002, 5, junk);
    selHigh3();
    chk("R8 abort midword m3 err", {15'd0, frameErr}, 16'd1);
    waitClk(4*H);
    chk("R9 err held idle", {15'd0, frameErr}, 16'd1);
    selLow3();
    runWords(16'h0000, 16'd2, 1'b0);
    selHigh3();
    chk("R8 restart data m3", got[2], chanVal[2]);
    chk("R9 err cleared m3", {15'd0, frameErr}, 16'd0);

    // R8: mode 3 abort on word boundary before frame end
    selLow3();
    doWord(16'h0000, W, junk);
    doWord(16'h0003, W, junk);
    selHigh3();
    chk("R8 abort boundary m3 err", {15'd0, frameErr}, 16'd1);
    selLow3();
    runWords(16'h0000, 16'd5, 1'b0);
    selHigh3();
    chk("R8 restart word0 m3", got[0], 16'h0000);
    chk("R8 restart data2 m3", got[2], chanVal[5]);

    // R8: mode 0 abort mid-word; R6 boundary pulses are not aborts
    setMode(1'b0);
    doWord(16'h0000, W, junk);
    doWord(16'h0001, 7, junk);
    chk("R8 abort midword m0 err", {15'd0, frameErr}, 16'd1);
    runWords(16'h0000, 16'd3, 1'b0);
    chk("R8 restart data m0", got[2], chanVal[3]);
    chk("R6 pulses no abort", {15'd0, frameErr}, 16'd0);
    chk("R11 miso idle end", {15'd0, miso}, 16'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule